// File: doc/BRIEF.md
# Root Hub Port Status Register Block

This block holds the register state of a USB host controller's root hub. A small 32-bit register bus reaches one hub-wide status word and up to four per-port status/control words. Each port word carries live state in its low half and sticky change flags in its high half. Software sets and clears port power, enable, suspend and reset by writing 1 to command bits. Connect, low-speed, overcurrent and reset-done indications arrive from port electrical logic as plain level or strobe inputs.

Port power can be dropped with one hub-level command. In global switching mode that command removes power from every port. In per-port mode a mask shields selected ports from it. Port writes that arrive while a bus transaction is running are parked, one per port, and take effect on the first clock edge at which the transaction has ended.

Top module: `rh_port_regs`

## Requirements
- R1: Word address 0 selects the hub word and address k (1..NUM_PORTS) selects port k-1. Any other address reads 0 and ignores writes. Reserved bits read 0. Reads are combinational from `bus_addr`, and all registers reset to 0.
- R2: Hub bit 0 always reads 0. Writing 1 to it issues a clear-power command on the same edge. Writing 0 to it leaves all port power untouched.
- R3: With `pwr_per_port_mode`=0, a clear-power command clears port power (bit 8) on every port.
- R4: With `pwr_per_port_mode`=1, a clear-power command clears port power only on ports whose `pwr_ctrl_mask` bit is 0.
- R5: Hub bit 1 equals `global_oc` when `oc_per_port`=0 and reads 0 when it is 1. Port bit 3 equals that port's `port_oc` when `oc_per_port`=1 and is 0 otherwise. Any change of port bit 3 sets port bit 19.
- R6: Port bit 0 registers `dev_connect` AND port power one edge after the input. Any change of bit 0 sets bit 16. Bit 9 reads `dev_lowspeed` AND bit 0. When bit 0 is 0, enable (1), suspend (2) and reset (4) are cleared.
- R7: Change flags (bits 16..20) are set by hardware and cleared only by writing 1 to them. A 0 leaves them unchanged, and a hardware set on the same edge wins.
- R8: Port command bits, acting on write 1: bit 0 clears enable; bit 1 sets enable if connected; bit 2 sets suspend if enabled; bit 3 ends a suspend and sets bit 18; bit 4 starts reset if connected; bit 8 sets power; bit 9 clears power together with enable, suspend and reset.
- R9: A `rst_done` strobe while a port's bit 4 is 1 clears bit 4, sets bit 20, and sets enable if the port is still connected.
- R10: A port write made while `xfer_busy`=1 has no visible effect until the first edge with `xfer_busy`=0, where it is applied. Clear-power commands are not deferred.
- R11: Only one parked write per port is kept. A newer write to the same port during the same transaction replaces the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| xfer_busy | input | 1 | A bus transaction is in progress |
| pwr_per_port_mode | input | 1 | 0 global power switching, 1 per-port |
| pwr_ctrl_mask | input | NUM_PORTS | Ports shielded from clear-power in per-port mode |
| oc_per_port | input | 1 | 1 selects per-port overcurrent reporting |
| global_oc | input | 1 | Hub-wide overcurrent level |
| dev_connect | input | NUM_PORTS | Device present per port |
| dev_lowspeed | input | NUM_PORTS | Attached device is low speed |
| port_oc | input | NUM_PORTS | Per-port overcurrent level |
| rst_done | input | NUM_PORTS | Port reset finished strobe |

## Verification
A write is applied on the rising edge during which `bus_sel` is held, so its effect is read back one edge later. Level inputs such as connect and overcurrent take one edge to reach the status word. A parked write lands on the edge after `xfer_busy` falls. The bench drives every input just after a falling edge and reads the combinational `bus_rdata` shortly after the following falling edge, so exactly one rising edge separates stimulus from observation. The power-clear sweep covers every mask in both modes on a three-port build.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int unsigned WORD_W = 32;

    // low half: live state / command bits
    localparam int unsigned B_CONN     = 0;
    localparam int unsigned B_ENA      = 1;
    localparam int unsigned B_SUSP     = 2;
    localparam int unsigned B_OC       = 3;
    localparam int unsigned B_RST      = 4;
    localparam int unsigned B_PWR      = 8;
    localparam int unsigned B_LS       = 9;
    // high half: sticky change flags
    localparam int unsigned B_CONN_CHG = 16;
    localparam int unsigned B_ENA_CHG  = 17;
    localparam int unsigned B_SUSP_CHG = 18;
    localparam int unsigned B_OC_CHG   = 19;
    localparam int unsigned B_RST_CHG  = 20;
    // hub word
    localparam int unsigned H_CLRPWR   = 0;
    localparam int unsigned H_OCI      = 1;

    typedef struct packed {
        logic              conn;
        logic              ena;
        logic              susp;
        logic              oc;
        logic              rst;
        logic              pwr;
        logic              conn_chg;
        logic              ena_chg;
        logic              susp_chg;
        logic              oc_chg;
        logic              rst_chg;
        logic              pend_vld;
        logic [WORD_W-1:0] pend_data;
    } port_state_t;

    function automatic port_state_t power_off(port_state_t s);
        port_state_t r;
        r      = s;
        r.pwr  = 1'b0;
        r.ena  = 1'b0;
        r.susp = 1'b0;
        r.rst  = 1'b0;
        return r;
    endfunction

    function automatic port_state_t apply_cmd(port_state_t s, logic [WORD_W-1:0] w);
        port_state_t r;
        r = s;
        if (w[B_CONN])             r.ena  = 1'b0;
        if (w[B_ENA] && r.conn)    r.ena  = 1'b1;
        if (w[B_SUSP] && r.ena)    r.susp = 1'b1;
        if (w[B_OC] && r.susp) begin
            r.susp     = 1'b0;
            r.susp_chg = 1'b1;
        end
        if (w[B_RST] && r.conn)    r.rst  = 1'b1;
        if (w[B_PWR])              r.pwr  = 1'b1;
        if (w[B_LS])               r      = power_off(r);
        if (w[B_CONN_CHG])         r.conn_chg = 1'b0;
        if (w[B_ENA_CHG])          r.ena_chg  = 1'b0;
        if (w[B_SUSP_CHG])         r.susp_chg = 1'b0;
        if (w[B_OC_CHG])           r.oc_chg   = 1'b0;
        if (w[B_RST_CHG])          r.rst_chg  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rh_port_slot.sv
module rh_port_slot
    import rh_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              xfer_busy,
    input  logic              clr_pwr,
    input  logic              dev_connect,
    input  logic              dev_lowspeed,
    input  logic              oc_in,
    input  logic              rst_done,
    output logic [WORD_W-1:0] status
);

    port_state_t s_d, s_q;
    logic        conn_new;

    always_comb begin
        s_d = s_q;

        // software commands, parked while a transaction runs
        if (xfer_busy) begin
            if (wr_en) begin
                s_d.pend_vld  = 1'b1;
                s_d.pend_data = wr_data;
            end
        end else begin
            if (s_q.pend_vld) s_d = apply_cmd(s_d, s_q.pend_data);
            s_d.pend_vld = 1'b0;
            if (wr_en) s_d = apply_cmd(s_d, wr_data);
        end

        // hub-level power removal is immediate
        if (clr_pwr) s_d = power_off(s_d);

        // hardware events; their flag sets win over same-edge clears
        conn_new = dev_connect & s_d.pwr;
        if (conn_new != s_q.conn) s_d.conn_chg = 1'b1;
        s_d.conn = conn_new;
        if (!conn_new) begin
            s_d.ena  = 1'b0;
            s_d.susp = 1'b0;
            s_d.rst  = 1'b0;
        end

        if (oc_in != s_q.oc) s_d.oc_chg = 1'b1;
        s_d.oc = oc_in;

        if (rst_done && s_q.rst) begin
            s_d.rst     = 1'b0;
            s_d.rst_chg = 1'b1;
            if (conn_new) s_d.ena = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status             = '0;
        status[B_CONN]     = s_q.conn;
        status[B_ENA]      = s_q.ena;
        status[B_SUSP]     = s_q.susp;
        status[B_OC]       = s_q.oc;
        status[B_RST]      = s_q.rst;
        status[B_PWR]      = s_q.pwr;
        status[B_LS]       = dev_lowspeed & s_q.conn;
        status[B_CONN_CHG] = s_q.conn_chg;
        status[B_ENA_CHG]  = s_q.ena_chg;
        status[B_SUSP_CHG] = s_q.susp_chg;
        status[B_OC_CHG]   = s_q.oc_chg;
        status[B_RST_CHG]  = s_q.rst_chg;
    end

endmodule

// File: rtl/rh_bus_decode.sv
module rh_bus_decode
    import rh_port_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                                bus_sel,
    input  logic                                bus_we,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                wdata_clr,
    input  logic                                pwr_per_port_mode,
    input  logic [NUM_PORTS-1:0]                pwr_ctrl_mask,
    input  logic                                oc_per_port,
    input  logic                                global_oc,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]    port_stat,
    output logic [NUM_PORTS-1:0]                port_wr,
    output logic [NUM_PORTS-1:0]                port_clr,
    output logic [WORD_W-1:0]                   rdata
);

    logic hub_hit;
    logic clr_req;

    assign hub_hit = (bus_addr == '0);
    assign clr_req = bus_sel & bus_we & hub_hit & wdata_clr;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_dec
        localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(i + 1);
        assign port_wr[i]  = bus_sel & bus_we & (bus_addr == PORT_ADDR);
        assign port_clr[i] = clr_req & (~pwr_per_port_mode | ~pwr_ctrl_mask[i]);
    end

    always_comb begin
        rdata = '0;
        if (hub_hit) rdata[H_OCI] = global_oc & ~oc_per_port;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (bus_addr == ADDR_W'(i + 1)) rdata = port_stat[i];
        end
    end

endmodule

// File: rtl/rh_port_regs.sv
module rh_port_regs
    import rh_port_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 xfer_busy,
    input  logic                 pwr_per_port_mode,
    input  logic [NUM_PORTS-1:0] pwr_ctrl_mask,
    input  logic                 oc_per_port,
    input  logic                 global_oc,
    input  logic [NUM_PORTS-1:0] dev_connect,
    input  logic [NUM_PORTS-1:0] dev_lowspeed,
    input  logic [NUM_PORTS-1:0] port_oc,
    input  logic [NUM_PORTS-1:0] rst_done
);

    logic [NUM_PORTS-1:0][WORD_W-1:0] port_stat;
    logic [NUM_PORTS-1:0]             port_wr;
    logic [NUM_PORTS-1:0]             port_clr;

    rh_bus_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .bus_sel           (bus_sel),
        .bus_we            (bus_we),
        .bus_addr          (bus_addr),
        .wdata_clr         (bus_wdata[H_CLRPWR]),
        .pwr_per_port_mode (pwr_per_port_mode),
        .pwr_ctrl_mask     (pwr_ctrl_mask),
        .oc_per_port       (oc_per_port),
        .global_oc         (global_oc),
        .port_stat         (port_stat),
        .port_wr           (port_wr),
        .port_clr          (port_clr),
        .rdata             (bus_rdata)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        rh_port_slot u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (port_wr[i]),
            .wr_data      (bus_wdata),
            .xfer_busy    (xfer_busy),
            .clr_pwr      (port_clr[i]),
            .dev_connect  (dev_connect[i]),
            .dev_lowspeed (dev_lowspeed[i]),
            .oc_in        (oc_per_port & port_oc[i]),
            .rst_done     (rst_done[i]),
            .status       (port_stat[i])
        );
    end

endmodule

// File: rtl/rh_port_regs_chk.sv
module rh_port_regs_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              bus_sel,
    input logic                              bus_we,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              wd0,
    input logic [31:0]                       bus_rdata,
    input logic                              xfer_busy,
    input logic                              pwr_per_port_mode,
    input logic [NUM_PORTS-1:0]              pwr_ctrl_mask,
    input logic                              oc_per_port,
    input logic [NUM_PORTS-1:0]              rst_done,
    input logic [NUM_PORTS-1:0][31:0]        port_stat
);

    logic                       past_ok;
    logic                       clr_cmd;
    logic [NUM_PORTS-1:0]       pwr_vec;
    logic [NUM_PORTS*5-1:0]     chg_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign clr_cmd = bus_sel & bus_we & (bus_addr == '0) & wd0;

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            pwr_vec[i]         = port_stat[i][8];
            chg_vec[i*5 +: 5]  = port_stat[i][20:16];
        end
    end

    // R1
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(NUM_PORTS)) |-> (bus_rdata == '0));

    // R3
    global_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(clr_cmd && !pwr_per_port_mode)) |-> (pwr_vec == '0));

    // R4
    masked_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(clr_cmd && pwr_per_port_mode))
            |-> ((pwr_vec & ~$past(pwr_ctrl_mask)) == '0));

    // R5
    hub_oc_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0 && oc_per_port) |-> (bus_rdata[1] == 1'b0));

    // R10
    busy_no_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(xfer_busy)) |-> (($past(chg_vec) & ~chg_vec) == '0));

    // R10
    busy_pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(xfer_busy && !clr_cmd)) |-> (pwr_vec == $past(pwr_vec)));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        // R9
        rst_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(rst_done[i] && port_stat[i][4]))
                |-> (port_stat[i][20] && !port_stat[i][4]));
    end

endmodule

bind rh_port_regs rh_port_regs_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_sel           (bus_sel),
    .bus_we            (bus_we),
    .bus_addr          (bus_addr),
    .wd0               (bus_wdata[0]),
    .bus_rdata         (bus_rdata),
    .xfer_busy         (xfer_busy),
    .pwr_per_port_mode (pwr_per_port_mode),
    .pwr_ctrl_mask     (pwr_ctrl_mask),
    .oc_per_port       (oc_per_port),
    .rst_done          (rst_done),
    .port_stat         (port_stat)
);

// File: tb/rh_port_regs_tb.sv
`timescale 1ns/1ps
module rh_port_regs_tb;

    localparam int unsigned NP = 3;
    localparam int unsigned AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          xfer_busy = 1'b0;
    logic          pwr_per_port_mode = 1'b0;
    logic [NP-1:0] pwr_ctrl_mask = '0;
    logic          oc_per_port = 1'b0;
    logic          global_oc = 1'b0;
    logic [NP-1:0] dev_connect = '0;
    logic [NP-1:0] dev_lowspeed = '0;
    logic [NP-1:0] port_oc = '0;
    logic [NP-1:0] rst_done = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rh_port_regs #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_busy(xfer_busy), .pwr_per_port_mode(pwr_per_port_mode),
        .pwr_ctrl_mask(pwr_ctrl_mask), .oc_per_port(oc_per_port),
        .global_oc(global_oc), .dev_connect(dev_connect),
        .dev_lowspeed(dev_lowspeed), .port_oc(port_oc), .rst_done(rst_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // write is captured by the rising edge between two falling edges
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, every address
        for (int a = 0; a < 8; a++) rd_chk("R1 reset", a, 32'h0);

        // R8: power on all ports
        for (int a = 1; a <= 3; a++) wr(a, 32'h100);
        rd_chk("R8 set power", 1, 32'h0000_0100);

        // R6: connect with low speed on port 1
        dev_connect = 3'b011; dev_lowspeed = 3'b010;
        rd_chk("R6 connect", 1, 32'h0001_0101);
        rd_chk("R6 lowspeed", 2, 32'h0001_0301);
        rd_chk("R6 idle port", 3, 32'h0000_0100);

        // R7: write 0 keeps flag, write 1 clears
        wr(1, 32'h0);
        rd_chk("R7 zero write", 1, 32'h0001_0101);
        wr(1, 32'h0001_0000);
        rd_chk("R7 w1c", 1, 32'h0000_0101);
        wr(2, 32'h0001_0000);

        // R8: enable, gated by connect
        wr(1, 32'h2);
        rd_chk("R8 enable", 1, 32'h0000_0103);
        wr(3, 32'h2);
        rd_chk("R8 enable unconnected", 3, 32'h0000_0100);

        // R9: reset sequence
        wr(1, 32'h10);
        rd_chk("R8 start reset", 1, 32'h0000_0113);
        tick(); rst_done = 3'b001;
        tick(); rst_done = 3'b000;
        rd_chk("R9 reset done", 1, 32'h0010_0103);
        wr(1, 32'h0010_0000);

        // R8: suspend and resume
        wr(1, 32'h4);
        rd_chk("R8 suspend", 1, 32'h0000_0107);
        wr(1, 32'h8);
        rd_chk("R8 resume", 1, 32'h0004_0103);
        wr(1, 32'h0004_0000);
        rd_chk("R7 clear suspend chg", 1, 32'h0000_0103);

        // R5: overcurrent reporting modes
        oc_per_port = 1'b1; port_oc = 3'b010; global_oc = 1'b1;
        rd_chk("R5 port oc", 2, 32'h0008_0309);
        rd_chk("R5 hub oc hidden", 0, 32'h0);
        oc_per_port = 1'b0;
        rd_chk("R5 hub oc global", 0, 32'h2);
        rd_chk("R5 port oc off", 2, 32'h0008_0301);
        port_oc = 3'b000; global_oc = 1'b0;
        wr(2, 32'h0008_0000);
        rd_chk("R7 clear oc chg", 2, 32'h0000_0301);

        // R10 / R11: deferral during a transaction
        tick(); xfer_busy = 1'b1;
        wr(2, 32'h200);
        rd_chk("R10 held", 2, 32'h0000_0301);
        wr(3, 32'h200);
        wr(3, 32'h0002_0000);
        rd_chk("R11 held", 3, 32'h0000_0100);
        tick(); xfer_busy = 1'b0;
        rd_chk("R10 applied", 2, 32'h0001_0000);
        rd_chk("R11 replaced", 3, 32'h0000_0100);

        // R2: writing 0 to the hub word does nothing
        wr(0, 32'h0);
        rd_chk("R2 zero write", 1, 32'h0000_0103);
        rd_chk("R2 bit0 reads 0", 0, 32'h0);

        // R1: unimplemented address ignores writes
        wr(4, 32'hFFFF_FFFF);
        rd_chk("R1 unimpl read", 4, 32'h0);
        rd_chk("R1 unimpl no side effect", 3, 32'h0000_0100);

        // R3 / R4: clear-power sweep over mode and mask
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 8; k++) begin
                for (int a = 1; a <= 3; a++) wr(a, 32'h100);
                tick();
                pwr_per_port_mode = m[0];
                pwr_ctrl_mask     = NP'(k);
                wr(0, 32'h1);
                for (int p = 0; p < 3; p++) begin
                    @(negedge clk);
                    bus_addr = AW'(p + 1);
                    #1;
                    check(m == 0 ? "R3 global clear" : "R4 masked clear",
                          32'(bus_rdata[8]),
                          (m == 0) ? 32'h0 : 32'((k >> p) & 1));
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule